// File: doc/BRIEF.md
# Flash Ready-Wait Status Poller

This block takes over once a serial NAND flash has been handed a read, program, erase or reset command. It has to learn when the flash has finished. It first lets an initial delay elapse, and the length of that delay depends on the kind of operation. It then asks a command engine for a one-byte status feature read. If the flash still reports busy, the block waits a shorter poll interval and asks again. The loop ends when the busy bit reads clear, or when the time spent waiting reaches a timeout budget while the flash is still busy.

Elapsed time is counted in pulses of a microsecond tick input. The shifting of bits on the serial bus belongs to the command engine. The block only raises a request, holds it until the engine acknowledges it with the status byte, and then decodes that byte. When the block finishes it raises a one-cycle completion pulse. In that same cycle it presents: ready or timed out, erase failure, program failure, and a three-way ECC outcome. All of these come from the last status byte read.

Top module: `rdyPollTop`

## Requirements
- R1: After reset, `active`, `cmdReq` and `done` are low.
- R2: A `start` pulse in an idle cycle captures `opType` (0 read, 1 program, 2 erase, 3 reset) and sets `active` in the next cycle. A `start` that arrives while `active` is high changes neither the operation type nor the timing.
- R3: The first status request goes out after an initial delay of `usTick` pulses, chosen by operation type. The defaults are 6 for read, 75 for program, 250 for erase and 5 for reset.
- R4: After each busy response, the next request goes out after a poll interval of `usTick` pulses, chosen by operation type. The defaults are 5 for read, 15 for program, 50 for erase and 5 for reset.
- R5: Every request carries feature address 0xC0 on `cmdAddr`. `cmdReq` stays high until the cycle in which `cmdAck` is sampled high, and `cmdData` is taken in that cycle.
- R6: A response with status bit 0 clear ends the wait. In that case `readyOk` is high and `timedOut` is low.
- R7: In the `done` cycle, `eraseFail` equals status bit 2 and `progFail` equals status bit 3 of the last status byte read.
- R8: In the `done` cycle, `eccOut` decodes status bits 5:4 as follows: 00 gives 0 (clean), 01 gives 1 (corrected), and 10 or 11 give 2 (uncorrectable). The value 3 never appears on `eccOut`.
- R9: A response with bit 0 set ends the wait with `timedOut` high and `readyOk` low when the delay ticks counted since start have reached `TIMEOUT_US`. The default is 400000. Otherwise the poll interval starts.
- R10: The delay and timeout counters advance only in cycles where `usTick` is high. With no ticks, no request is ever issued.
- R11: `done` is a single-cycle pulse. It rises in the cycle after the final acknowledged response, and `active` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin waiting for the operation just issued |
| opType | input | 2 | Operation kind: 0 read, 1 program, 2 erase, 3 reset |
| active | output | 1 | A wait is in progress |
| cmdReq | output | 1 | Request a status feature read from the command engine |
| cmdAddr | output | 8 | Feature address of the request (0xC0) |
| cmdAck | input | 1 | Command engine returns the status byte this cycle |
| cmdData | input | 8 | Status byte returned with `cmdAck` |
| done | output | 1 | One-cycle completion pulse |
| readyOk | output | 1 | Flash reported ready (valid with `done`) |
| timedOut | output | 1 | Gave up while still busy (valid with `done`) |
| eraseFail | output | 1 | Erase failure flag (valid with `done`) |
| progFail | output | 1 | Program failure flag (valid with `done`) |
| eccOut | output | 2 | 0 clean, 1 corrected, 2 uncorrectable (valid with `done`) |

## Verification
With a tick in every cycle, the first request rises D cycles after the start edge, where D is the initial delay, and the response is taken one edge later. Each further busy round adds the poll interval plus one request cycle. `done` therefore rises D+1+(n-1)(P+1) edges after the start edge for n reads. The bench predicts this count from the delay table and the number of busy responses it serves, and compares it with the number of clock edges it sees before `done`. All outputs are sampled on falling edges. The number of reads, the timeout verdict and every decoded flag are worked out arithmetically from the served status bytes and checked in the `done` cycle. The cycle after `done` is checked separately.

// File: rtl/rdyPollPkg.sv
package rdyPollPkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_LOST  = 2'd2
  } eccRes_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armStart;  // load initial delay, clear elapsed time
    logic armPoll;   // load poll interval
    logic sample;    // take the returned status byte
  } ctlStrb_t;

  localparam logic [7:0] STATUS_FEAT_ADDR = 8'hC0;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_EFAIL = 2;
  localparam int BIT_PFAIL = 3;
  localparam int BIT_ECCLO = 4;
  localparam int BIT_ECCHI = 5;

endpackage

// File: rtl/rdyPollDp.sv
module rdyPollDp
  import rdyPollPkg::*;
#(
  parameter int RD_INIT_US  = 6,
  parameter int RD_POLL_US  = 5,
  parameter int PG_INIT_US  = 75,
  parameter int PG_POLL_US  = 15,
  parameter int ER_INIT_US  = 250,
  parameter int ER_POLL_US  = 50,
  parameter int RS_INIT_US  = 5,
  parameter int RS_POLL_US  = 5,
  parameter int TIMEOUT_US  = 400000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  opKind_e    opIn,
  input  ctlStrb_t   strb,
  input  logic       waitPhase,
  input  logic [7:0] cmdData,
  output logic       delayDone,
  output logic       timeUp,
  output logic       timedOut,
  output logic       eraseFail,
  output logic       progFail,
  output logic [1:0] eccOut
);

  localparam int MAX_A  = (RD_INIT_US > PG_INIT_US) ? RD_INIT_US : PG_INIT_US;
  localparam int MAX_B  = (ER_INIT_US > RS_INIT_US) ? ER_INIT_US : RS_INIT_US;
  localparam int MAX_C  = (RD_POLL_US > PG_POLL_US) ? RD_POLL_US : PG_POLL_US;
  localparam int MAX_D  = (ER_POLL_US > RS_POLL_US) ? ER_POLL_US : RS_POLL_US;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CD = (MAX_C > MAX_D) ? MAX_C : MAX_D;
  localparam int MAX_DLY = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int DW = $clog2(MAX_DLY + 1);
  localparam int TW = $clog2(TIMEOUT_US + 1);
  localparam logic [TW-1:0] T_LIMIT = TW'(TIMEOUT_US);

  function automatic logic [DW-1:0] pickDelay(input opKind_e op, input logic poll);
    logic [DW-1:0] v;
    case (op)
      OP_READ:  v = poll ? DW'(RD_POLL_US) : DW'(RD_INIT_US);
      OP_PROG:  v = poll ? DW'(PG_POLL_US) : DW'(PG_INIT_US);
      OP_ERASE: v = poll ? DW'(ER_POLL_US) : DW'(ER_INIT_US);
      default:  v = poll ? DW'(RS_POLL_US) : DW'(RS_INIT_US);
    endcase
    return v;
  endfunction

  opKind_e       opQ;
  logic [DW-1:0] dlyCnt;
  logic [TW-1:0] elapsed;
  logic [3:0]    statQ;   // {ecc hi, ecc lo, prog fail, erase fail}
  logic          toQ;
  logic          unusedStatBits;

  assign unusedStatBits = ^{cmdData[7:6], cmdData[1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= OP_READ;
      dlyCnt  <= '0;
      elapsed <= '0;
    end else if (strb.armStart) begin
      opQ     <= opIn;
      dlyCnt  <= pickDelay(opIn, 1'b0);
      elapsed <= '0;
    end else if (strb.armPoll) begin
      dlyCnt  <= pickDelay(opQ, 1'b1);
    end else if (waitPhase && usTick) begin
      dlyCnt <= dlyCnt - DW'(1);
      if (elapsed < T_LIMIT) elapsed <= elapsed + TW'(1);
    end
  end

  assign delayDone = waitPhase && usTick && (dlyCnt == DW'(1));
  assign timeUp    = (elapsed >= T_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      toQ   <= 1'b0;
    end else if (strb.sample) begin
      statQ <= {cmdData[BIT_ECCHI], cmdData[BIT_ECCLO],
                cmdData[BIT_PFAIL], cmdData[BIT_EFAIL]};
      toQ   <= cmdData[BIT_BUSY] && timeUp;
    end
  end

  assign timedOut  = toQ;
  assign eraseFail = statQ[0];
  assign progFail  = statQ[1];
  always_comb begin
    case (statQ[3:2])
      2'b00:   eccOut = ECC_CLEAN;
      2'b01:   eccOut = ECC_FIXED;
      default: eccOut = ECC_LOST;
    endcase
  end

  // R9: elapsed time saturates at the budget
  a_r9_elapsed_cap: assert property (@(posedge clk) disable iff (!rstN)
    elapsed <= T_LIMIT);
  // R3: a delay being waited out always has ticks left to count
  a_r3_wait_count_live: assert property (@(posedge clk) disable iff (!rstN)
    waitPhase |-> dlyCnt != '0);

endmodule

// File: rtl/rdyPollCtrl.sv
module rdyPollCtrl
  import rdyPollPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     delayDone,
  input  logic     cmdAck,
  input  logic     statBusy,
  input  logic     timeUp,
  output ctlStrb_t strb,
  output logic     waitPhase,
  output logic     cmdReq,
  output logic     active,
  output logic     done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ} state_e;

  state_e state, stateNx;
  logic   finishNow;

  always_comb begin
    stateNx   = state;
    strb      = '0;
    finishNow = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        strb.armStart = 1'b1;
        stateNx       = S_WAIT;
      end
      S_WAIT: if (delayDone) stateNx = S_REQ;
      S_REQ: if (cmdAck) begin
        strb.sample = 1'b1;
        if (!statBusy || timeUp) begin
          finishNow = 1'b1;
          stateNx   = S_IDLE;
        end else begin
          strb.armPoll = 1'b1;
          stateNx      = S_WAIT;
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNx;
      done  <= finishNow;
    end
  end

  assign waitPhase = (state == S_WAIT);
  assign cmdReq    = (state == S_REQ);
  assign active    = (state != S_IDLE);

  // R5: a request is held until acknowledged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdAck) |=> cmdReq);
  // R2: an idle start begins a wait
  a_r2_start_takes: assert property (@(posedge clk) disable iff (!rstN)
    (start && !active) |=> active);
  // R11: completion follows an acknowledged response, once
  a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(cmdAck));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !active);

endmodule

// File: rtl/rdyPollTop.sv
module rdyPollTop
  import rdyPollPkg::*;
#(
  parameter int RD_INIT_US = 6,
  parameter int RD_POLL_US = 5,
  parameter int PG_INIT_US = 75,
  parameter int PG_POLL_US = 15,
  parameter int ER_INIT_US = 250,
  parameter int ER_POLL_US = 50,
  parameter int RS_INIT_US = 5,
  parameter int RS_POLL_US = 5,
  parameter int TIMEOUT_US = 400000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       start,
  input  logic [1:0] opType,
  output logic       active,
  output logic       cmdReq,
  output logic [7:0] cmdAddr,
  input  logic       cmdAck,
  input  logic [7:0] cmdData,
  output logic       done,
  output logic       readyOk,
  output logic       timedOut,
  output logic       eraseFail,
  output logic       progFail,
  output logic [1:0] eccOut
);

  ctlStrb_t strb;
  logic     waitPhase, delayDone, timeUp;

  rdyPollCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .delayDone (delayDone),
    .cmdAck    (cmdAck),
    .statBusy  (cmdData[BIT_BUSY]),
    .timeUp    (timeUp),
    .strb      (strb),
    .waitPhase (waitPhase),
    .cmdReq    (cmdReq),
    .active    (active),
    .done      (done)
  );

  rdyPollDp #(
    .RD_INIT_US (RD_INIT_US), .RD_POLL_US (RD_POLL_US),
    .PG_INIT_US (PG_INIT_US), .PG_POLL_US (PG_POLL_US),
    .ER_INIT_US (ER_INIT_US), .ER_POLL_US (ER_POLL_US),
    .RS_INIT_US (RS_INIT_US), .RS_POLL_US (RS_POLL_US),
    .TIMEOUT_US (TIMEOUT_US)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .usTick    (usTick),
    .opIn      (opKind_e'(opType)),
    .strb      (strb),
    .waitPhase (waitPhase),
    .cmdData   (cmdData),
    .delayDone (delayDone),
    .timeUp    (timeUp),
    .timedOut  (timedOut),
    .eraseFail (eraseFail),
    .progFail  (progFail),
    .eccOut    (eccOut)
  );

  assign cmdAddr = STATUS_FEAT_ADDR;
  assign readyOk = done && !timedOut;

  // R9: a timeout verdict only follows a busy status byte
  a_r9_timeout_busy: assert property (@(posedge clk) disable iff (!rstN)
    (done && timedOut) |-> $past(cmdData[BIT_BUSY]));
  // R6: ready is only reported after a status byte with busy clear
  a_r6_ready_clear: assert property (@(posedge clk) disable iff (!rstN)
    (done && readyOk) |-> !$past(cmdData[BIT_BUSY]));
  // R8: the unused ECC code is never emitted
  a_r8_ecc_code: assert property (@(posedge clk) disable iff (!rstN)
    done |-> eccOut != 2'b11);

endmodule

// File: tb/tb_rdyPollTop.sv
`timescale 1ns/1ps
module tb_rdyPollTop;

  localparam int TMO = 1000;
  localparam logic [7:0] BUSY_BYTE = 8'h3D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b1;
  logic start = 1'b0;
  logic [1:0] opType = 2'd0;
  logic active, cmdReq, done, readyOk, timedOut, eraseFail, progFail;
  logic [7:0] cmdAddr;
  logic cmdAck = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic [1:0] eccOut;

  int errors = 0;
  int checks = 0;
  int served = 0;
  int nBusy = 0;
  int badAddr = 0;
  logic [7:0] finalByte = 8'h00;

  always #2 clk = ~clk;

  rdyPollTop #(.TIMEOUT_US(TMO)) dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .start(start), .opType(opType),
    .active(active), .cmdReq(cmdReq), .cmdAddr(cmdAddr), .cmdAck(cmdAck),
    .cmdData(cmdData), .done(done), .readyOk(readyOk), .timedOut(timedOut),
    .eraseFail(eraseFail), .progFail(progFail), .eccOut(eccOut)
  );

  // command engine model: acknowledges one edge after a request is seen
  always @(negedge clk) begin
    if (cmdReq && !cmdAck) begin
      if (cmdAddr != 8'hC0) badAddr++;
      cmdAck  <= 1'b1;
      cmdData <= (served < nBusy) ? BUSY_BYTE : finalByte;
      served++;
    end else begin
      cmdAck  <= 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  function automatic int initOf(input int op);
    case (op) 0: return 6; 1: return 75; 2: return 250; default: return 5; endcase
  endfunction
  function automatic int pollOf(input int op);
    case (op) 0: return 5; 1: return 15; 2: return 50; default: return 5; endcase
  endfunction

  // one wait: returns after the cycle following done has been checked
  task automatic runOp(input int op, input int busyCnt, input logic [7:0] fin,
                       input bit dupStart);
    int cyc, reads, elapsedAt;
    bit expTo;
    logic [7:0] lastB;
    nBusy = busyCnt; finalByte = fin; served = 0; badAddr = 0;
    // expected reads and verdict
    reads = 0; expTo = 0;
    for (int k = 1; k <= busyCnt + 1; k++) begin
      elapsedAt = initOf(op) + (k - 1) * pollOf(op);
      reads = k;
      if (k > busyCnt) break;
      if (elapsedAt >= TMO) begin expTo = 1; break; end
    end
    lastB = expTo ? BUSY_BYTE : fin;
    @(negedge clk);
    start = 1'b1; opType = op[1:0];
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      if (dupStart && cyc == 3) begin start = 1'b1; opType = 2'd2; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    // R3 R4 R11: completion cycle from delay table
    check("R3/R4 cycles to done", cyc, initOf(op) + 2 + (reads - 1) * (pollOf(op) + 1));
    check("R4/R9 status reads", served, reads);
    check("R5 feature address", badAddr, 0);
    check("R6 readyOk", int'(readyOk), int'(!expTo));
    check("R9 timedOut", int'(timedOut), int'(expTo));
    check("R7 eraseFail", int'(eraseFail), int'(lastB[2]));
    check("R7 progFail", int'(progFail), int'(lastB[3]));
    check("R8 eccOut", int'(eccOut), (lastB[5:4] == 2'b00) ? 0 : (lastB[5:4] == 2'b01) ? 1 : 2);
    check("R11 active low at done", int'(active), 0);
    @(negedge clk);
    check("R11 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 active", int'(active), 0);
    check("R1 cmdReq", int'(cmdReq), 0);
    check("R1 done", int'(done), 0);
    rstN = 1'b1;

    // R3 R4 R6 R7 R8: sweep of ops, busy rounds, status fields
    for (int op = 0; op < 4; op++)
      for (int nb = 0; nb < 4; nb += 2)
        for (int f = 0; f < 16; f++)
          runOp(op, nb, {2'b10, f[3:0], 2'b00} | ((f % 3 == 0) ? 8'h02 : 8'h00), 1'b0);
    for (int op = 0; op < 4; op++) runOp(op, 1, 8'h20, 1'b0);

    // R9: always busy until budget reached
    for (int op = 0; op < 4; op++) runOp(op, 100000, 8'h00, 1'b0);

    // R2: start during a wait is ignored (read timing kept)
    runOp(0, 1, 8'h10, 1'b1);

    // R10: no ticks means no progress
    begin
      int cyc;
      int sawReq;
      nBusy = 0; finalByte = 8'h00; served = 0; sawReq = 0;
      usTick = 1'b0;
      @(negedge clk);
      start = 1'b1; opType = 2'd3;
      @(negedge clk);
      start = 1'b0;
      repeat (40) begin
        if (cmdReq) sawReq++;
        @(negedge clk);
      end
      check("R10 no request without ticks", sawReq, 0);
      check("R10 still active", int'(active), 1);
      usTick = 1'b1;
      cyc = 0;
      while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
      check("R10 cycles after ticks resume", cyc, 5 + 1);
      check("R10 ready", int'(readyOk), 1);
    end

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule